// File: doc/BRIEF.md
# Spindle Motor Idle Timeout Controller

This block drives the motor enable bits of up to four disk drives through an eight-bit control byte, alongside a drive select field and two controller enable bits. When a request names a drive whose motor is stopped, the block sets that motor bit and holds the request back for a spin-up interval, counted in clock cycles. When it finishes that wait, it pulses a ready strobe. A request to a drive that is already spinning is released one cycle later.

Each drive has its own idle counter. The counter advances on a once-per-second tick while the motor runs, and the motor is switched off once the counter reaches a fixed limit. Any access to a drive clears its counter. A drive that is waiting on a shared transfer resource can have its counter frozen, so that it never times out during the wait. If the drive that times out is the selected drive and an operation is still in progress, the block raises a one-cycle recovery pulse in the same cycle as the motor bit drops. Tick processing stops whenever every motor bit is clear.

Top module: `spindle_idle_ctrl`

## Requirements
- R1: After reset, dor_q is 8'h0C (controller run bit 2 and interrupt/DMA enable bit 3 set, all motors off, select 0), and spinup_done, recover_pulse and tick_armed are low.
- R2: dor_q bits 3:2 are always 2'b11. Bits 1:0 hold the drive number of the last accepted request. Bit 4+n is the motor enable of drive n.
- R3: An accepted request to a drive whose motor is off sets that drive's motor bit and select field at the next clock edge. spinup_done is a single-cycle pulse that appears SPINUP_CYCLES edges after the accepting edge.
- R4: An accepted request to a drive whose motor is already on raises spinup_done at the next edge for one cycle, and leaves the motor bits unchanged.
- R5: A request that arrives while a spin-up wait is in progress is ignored. The motor bits, the select field and the pending spinup_done timing are all unaffected.
- R6: While a drive's motor is on and its counter is not frozen, each sec_tick advances its idle count. The motor bit clears at the edge of the IDLE_LIMIT-th tick (default 5) since the drive's last access.
- R7: A touch_valid strobe naming a drive clears that drive's idle count to zero.
- R8: While a drive is frozen (hold_set seen, no hold_clr since), ticks do not advance its count and its motor bit never clears. After hold_clr, the count resumes from its held value.
- R9: When the timed-out drive is the selected drive and op_busy is high on that tick, recover_pulse is high for exactly the one cycle in which the motor bit first reads clear.
- R10: A timeout of a drive that is not selected, or of a drive that times out while op_busy is low, raises no recover_pulse.
- R11: tick_armed is high exactly when any motor bit is set. A tick seen while all motors are off changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| req_valid | input | 1 | Operation request strobe |
| req_unit | input | 2 | Drive targeted by the request |
| touch_valid | input | 1 | Access strobe that clears a drive's idle count |
| touch_unit | input | 2 | Drive named by touch_valid |
| hold_set | input | 1 | Freeze the idle count of hold_unit |
| hold_clr | input | 1 | Unfreeze the idle count of hold_unit |
| hold_unit | input | 2 | Drive named by hold_set or hold_clr |
| op_busy | input | 1 | An operation is in progress on the selected drive |
| dor_q | output | 8 | Control byte: motors, enables, select |
| spinup_done | output | 1 | One-cycle pulse: request may proceed |
| recover_pulse | output | 1 | One-cycle pulse: busy drive timed out |
| tick_armed | output | 1 | Any motor running; ticks are processed |

## Verification
A wrong idle count shows up at the ports only when a tick arrives. The fault appears as a motor bit in dor_q that clears one tick early or late, so the bench checks the byte after every single tick across a full idle window. A stuck freeze or an uncleared count surfaces within at most IDLE_LIMIT ticks as a premature or missing motor drop. A wrong spin-up state shows as a spinup_done pulse on the wrong cycle, or as a second pulse. A wrong select field shows immediately in dor_q bits 1:0, and it also shows at the next timeout as a recovery pulse raised for the wrong drive.

// File: rtl/spindle_pkg.sv
package spindle_pkg;
  localparam int NUM_DRIVES = 4;
  localparam int SEL_W      = $clog2(NUM_DRIVES);
  localparam int CTRL_W     = 8;
  localparam int MOTOR_LSB  = 4;
  localparam logic [1:0] CTL_ENABLES = 2'b11;
endpackage

// File: rtl/spindle_idle_counter.sv
module spindle_idle_counter #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic frozen,
  input  logic clear,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = tick & run & ~frozen & ~clear;
  assign expire = step & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spindle_spinup_timer.sv
module spindle_spinup_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_wait,
  input  logic start_now,
  output logic waiting,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      done    <= 1'b0;
      left_q  <= '0;
    end else if (start_wait) begin
      waiting <= 1'b1;
      done    <= 1'b0;
      left_q  <= CW'(CYCLES - 1);
    end else if (start_now) begin
      done    <= 1'b1;
    end else if (waiting) begin
      if (left_q == '0) begin
        waiting <= 1'b0;
        done    <= 1'b1;
      end else begin
        left_q  <= left_q - 1'b1;
        done    <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/spindle_idle_ctrl.sv
module spindle_idle_ctrl
  import spindle_pkg::*;
#(
  parameter int IDLE_LIMIT    = 5,
  parameter int SPINUP_CYCLES = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_unit,
  input  logic              touch_valid,
  input  logic [SEL_W-1:0]  touch_unit,
  input  logic              hold_set,
  input  logic              hold_clr,
  input  logic [SEL_W-1:0]  hold_unit,
  input  logic              op_busy,
  output logic [CTRL_W-1:0] dor_q,
  output logic              spinup_done,
  output logic              recover_pulse,
  output logic              tick_armed
);
  logic [NUM_DRIVES-1:0] motor_q;
  logic [NUM_DRIVES-1:0] hold_q;
  logic [NUM_DRIVES-1:0] expire;
  logic [NUM_DRIVES-1:0] clr_cnt;
  logic [SEL_W-1:0]      sel_q;
  logic                  spin_wait;
  logic                  accept;
  logic                  start_wait;
  logic                  start_now;
  logic                  scan_tick;

  assign accept     = req_valid & ~spin_wait;
  assign start_wait = accept & ~motor_q[req_unit];
  assign start_now  = accept &  motor_q[req_unit];
  assign tick_armed = |motor_q;
  assign scan_tick  = sec_tick & tick_armed;

  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
    assign clr_cnt[i] = (accept && req_unit == SEL_W'(i)) ||
                        (touch_valid && touch_unit == SEL_W'(i));

    spindle_idle_counter #(.LIMIT(IDLE_LIMIT)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick   (scan_tick),
      .run    (motor_q[i]),
      .frozen (hold_q[i]),
      .clear  (clr_cnt[i]),
      .expire (expire[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[i] <= 1'b0;
      end else if (hold_set && hold_unit == SEL_W'(i)) begin
        hold_q[i] <= 1'b1;
      end else if (hold_clr && hold_unit == SEL_W'(i)) begin
        hold_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        motor_q[i] <= 1'b0;
      end else if (accept && req_unit == SEL_W'(i)) begin
        motor_q[i] <= 1'b1;
      end else if (expire[i]) begin
        motor_q[i] <= 1'b0;
      end
    end
  end

  spindle_spinup_timer #(.CYCLES(SPINUP_CYCLES)) u_spin (
    .clk        (clk),
    .rst        (rst),
    .start_wait (start_wait),
    .start_now  (start_now),
    .waiting    (spin_wait),
    .done       (spinup_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q         <= '0;
      recover_pulse <= 1'b0;
    end else begin
      if (accept) sel_q <= req_unit;
      recover_pulse <= op_busy & expire[sel_q];
    end
  end

  always_comb begin
    dor_q = {motor_q, CTL_ENABLES, sel_q};
  end
endmodule

// File: rtl/spindle_idle_chk.sv
module spindle_idle_chk
  import spindle_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              req_valid,
  input logic [SEL_W-1:0]  req_unit,
  input logic              op_busy,
  input logic [CTRL_W-1:0] dor_q,
  input logic              spinup_done,
  input logic              recover_pulse,
  input logic              tick_armed,
  input logic [NUM_DRIVES-1:0] hold_q,
  input logic              spin_wait
);
  // R3
  motor_on_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !spin_wait) |=>
      ((dor_q[CTRL_W-1:MOTOR_LSB] & (NUM_DRIVES'(1) << $past(req_unit))) != '0));

  // R6
  motor_off_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(dor_q[CTRL_W-1:MOTOR_LSB]) & ~dor_q[CTRL_W-1:MOTOR_LSB]) != '0) |-> $past(sec_tick));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((hold_q & dor_q[CTRL_W-1:MOTOR_LSB]) != '0) |=>
      (($past(hold_q) & $past(dor_q[CTRL_W-1:MOTOR_LSB]) & ~dor_q[CTRL_W-1:MOTOR_LSB]) == '0));

  // R9
  recover_cause_chk: assert property (@(posedge clk) disable iff (rst)
    recover_pulse |-> ($past(sec_tick) && $past(op_busy)));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    spin_wait |-> !spinup_done);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_armed && !req_valid) |=> (dor_q[CTRL_W-1:MOTOR_LSB] == '0 && !recover_pulse));
endmodule

bind spindle_idle_ctrl spindle_idle_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .sec_tick      (sec_tick),
  .req_valid     (req_valid),
  .req_unit      (req_unit),
  .op_busy       (op_busy),
  .dor_q         (dor_q),
  .spinup_done   (spinup_done),
  .recover_pulse (recover_pulse),
  .tick_armed    (tick_armed),
  .hold_q        (hold_q),
  .spin_wait     (spin_wait)
);

// File: tb/spindle_idle_ctrl_bench.sv
`timescale 1ns/1ps
module spindle_idle_ctrl_bench;
  localparam int SPIN = 8;
  localparam int LIM  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 0, req_valid = 0, touch_valid = 0;
  logic       hold_set = 0, hold_clr = 0, op_busy = 0;
  logic [1:0] req_unit = 0, touch_unit = 0, hold_unit = 0;
  logic [7:0] dor_q;
  logic       spinup_done, recover_pulse, tick_armed;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    int         at;
    logic [7:0] dor;
    logic       done;
    logic       rec;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spindle_idle_ctrl #(.IDLE_LIMIT(LIM), .SPINUP_CYCLES(SPIN)) u_spindle_idle_ctrl (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .req_valid(req_valid), .req_unit(req_unit),
    .touch_valid(touch_valid), .touch_unit(touch_unit),
    .hold_set(hold_set), .hold_clr(hold_clr), .hold_unit(hold_unit),
    .op_busy(op_busy), .dor_q(dor_q), .spinup_done(spinup_done),
    .recover_pulse(recover_pulse), .tick_armed(tick_armed)
  );

  function automatic void chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "dor_q", dor_q, e.dor);
      chk(e.tag, "spinup_done", {7'd0, spinup_done}, {7'd0, e.done});
      chk(e.tag, "recover_pulse", {7'd0, recover_pulse}, {7'd0, e.rec});
    end
  end

  task automatic expect_at(int off, logic [7:0] dor, logic done, logic rec, string tag);
    exp_t e;
    e.at = cyc + off; e.dor = dor; e.done = done; e.rec = rec; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(logic [1:0] u);
    req_valid = 1; req_unit = u;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_touch(logic [1:0] u);
    touch_valid = 1; touch_unit = u;
    @(negedge clk);
    touch_valid = 0;
  endtask

  task automatic do_hold(logic set, logic [1:0] u);
    hold_set = set; hold_clr = !set; hold_unit = u;
    @(negedge clk);
    hold_set = 0; hold_clr = 0;
  endtask

  task automatic do_tick();
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic ticks_hold(int n, logic [7:0] dor, string tag);
    for (int k = 0; k < n; k++) begin
      expect_at(1, dor, 0, 0, tag);
      do_tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "dor_q", dor_q, 8'h0C);
    chk("R1", "flags", {5'd0, spinup_done, recover_pulse, tick_armed}, 8'h00);

    // R3 spin-up on a stopped drive
    expect_at(1, 8'h2D, 0, 0, "R3");
    expect_at(SPIN, 8'h2D, 0, 0, "R3");
    expect_at(SPIN + 1, 8'h2D, 1, 0, "R3");
    expect_at(SPIN + 2, 8'h2D, 0, 0, "R3");
    do_req(2'd1);
    idle(SPIN + 3);
    chk("R11", "tick_armed", {7'd0, tick_armed}, 8'h01);

    // R4 request to a running drive
    expect_at(1, 8'h2D, 1, 0, "R4");
    expect_at(2, 8'h2D, 0, 0, "R4");
    do_req(2'd1);
    idle(2);

    // R6 idle timeout after LIM ticks
    ticks_hold(LIM - 1, 8'h2D, "R6");
    expect_at(1, 8'h0D, 0, 0, "R6");
    do_tick();
    chk("R11", "tick_armed", {7'd0, tick_armed}, 8'h00);
    // R11 tick with all motors off does nothing
    expect_at(1, 8'h0D, 0, 0, "R11");
    expect_at(2, 8'h0D, 0, 0, "R11");
    do_tick();
    idle(1);

    // R7 touch clears the idle count, R2 select field
    expect_at(1, 8'h1C, 0, 0, "R2");
    do_req(2'd0);
    idle(SPIN + 2);
    ticks_hold(3, 8'h1C, "R7");
    do_touch(2'd0);
    ticks_hold(LIM - 1, 8'h1C, "R7");
    expect_at(1, 8'h0C, 0, 0, "R7");
    do_tick();

    // R8 frozen drive never times out
    expect_at(1, 8'h4E, 0, 0, "R8");
    do_req(2'd2);
    idle(SPIN + 2);
    do_hold(1'b1, 2'd2);
    ticks_hold(7, 8'h4E, "R8");
    do_hold(1'b0, 2'd2);
    ticks_hold(LIM - 1, 8'h4E, "R8");
    expect_at(1, 8'h0E, 0, 0, "R8");
    do_tick();

    // R9 busy selected drive times out
    op_busy = 1;
    expect_at(1, 8'h8F, 0, 0, "R9");
    do_req(2'd3);
    idle(SPIN + 2);
    ticks_hold(LIM - 1, 8'h8F, "R9");
    expect_at(1, 8'h0F, 0, 1, "R9");
    expect_at(2, 8'h0F, 0, 0, "R9");
    do_tick();
    idle(1);
    op_busy = 0;

    // R10 non-selected drive times out while busy: no recovery
    expect_at(1, 8'h1C, 0, 0, "R10");
    do_req(2'd0);
    idle(SPIN + 2);
    ticks_hold(2, 8'h1C, "R10");
    op_busy = 1;
    expect_at(1, 8'h3D, 0, 0, "R10");
    do_req(2'd1);
    idle(SPIN + 2);
    ticks_hold(2, 8'h3D, "R10");
    expect_at(1, 8'h2D, 0, 0, "R10");
    do_tick();
    ticks_hold(1, 8'h2D, "R10");
    expect_at(1, 8'h0D, 0, 1, "R9");
    expect_at(2, 8'h0D, 0, 0, "R9");
    do_tick();
    idle(1);
    op_busy = 0;

    // R10 selected drive times out while not busy
    expect_at(1, 8'h2D, 0, 0, "R10");
    do_req(2'd1);
    idle(SPIN + 2);
    ticks_hold(LIM - 1, 8'h2D, "R10");
    expect_at(1, 8'h0D, 0, 0, "R10");
    expect_at(2, 8'h0D, 0, 0, "R10");
    do_tick();
    idle(1);

    // R5 request during spin-up is ignored
    expect_at(1, 8'h4E, 0, 0, "R5");
    do_req(2'd2);
    idle(1);
    expect_at(1, 8'h4E, 0, 0, "R5");
    expect_at(SPIN - 2, 8'h4E, 0, 0, "R5");
    expect_at(SPIN - 1, 8'h4E, 1, 0, "R5");
    expect_at(SPIN, 8'h4E, 0, 0, "R5");
    do_req(2'd3);
    idle(SPIN + 2);

    while (sb_q.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done (cycle %0d)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule